// File: doc/BRIEF.md
# Non-Volatile Array Guard Controller

This block sits in front of a word-addressed non-volatile array, modelled here as on-chip RAM. It has two ports. The first is a small register port that software uses to pick an access mode, start erases and poll for completion. The second is a data port through which the host reads and writes the array words directly. The array has two parts: a main region built from a parameterised number of equal pages, and a small separate user configuration region.

A two-bit mode register gates all changes to the array. In read-only mode nothing can change. Write mode lets host writes through the data port. Erase mode lets three erase commands through: one page, the whole main region, or the whole user region. An erase is carried out by a sequencer that writes all ones to one word per clock cycle. While it runs, the ready flag reads 0.

Register indices on the register port are `0` ready (read only), `1` mode, `2` and `3` page erase, `4` main erase, `5` user erase. The erase registers are write only and read as 0. Any other index also reads as 0.

Top module: `fmc_ctrl`

## Requirements
- R1: Bit 0 of register 0 (ready) reads 1 when no erase is running. All other bits of that register read 0. Ready reads 0 from the clock edge that accepts an erase command until the edge that writes the last word of that erase. An erase of N words keeps ready at 0 for exactly N cycles.
- R2: Register 1 (mode) is 2 bits wide and resets to 0. Any value from 0 to 3 written to it reads back unchanged. The mode values are: 0 read-only, 1 write, 2 erase, 3 reserved.
- R3: A data-port write is stored only when mode is 1 and no erase is running. The stored word is returned by the combinational data-port read on the cycle after the write edge. In mode 0, 2 or 3 the write leaves the word unchanged.
- R4: In mode 2, writing a word address to register 2 or register 3 erases the page that holds that address. The page index is taken from address bits [MAIN_AW-1:log2(PAGE_WORDS)]. Higher bits are ignored, so the page index wraps.
- R5: In mode 2, a write to register 4 with bit 0 set writes all ones to every word of the main region. The user region is left unchanged.
- R6: In mode 2, a write to register 5 with bit 0 set writes all ones to every word of the user region. The main region is left unchanged.
- R7: An erase command is ignored in each of these cases: mode is not 2; an erase is already running; or, for registers 4 and 5, bit 0 of the written value is 0. An ignored command leaves ready at 1 and leaves every word unchanged.
- R8: An erase writes only all-ones words, and writes only to the words of its target. Words just outside an erased page keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | DATA_W | Register write value |
| reg_rdata | output | DATA_W | Register read value (combinational) |
| arr_we | input | 1 | Data-port write strobe |
| arr_user | input | 1 | Data-port region select: 1 user region, 0 main region |
| arr_addr | input | MAIN_AW | Data-port word address; the user region uses its low bits |
| arr_wdata | input | DATA_W | Data-port write word |
| arr_rdata | output | DATA_W | Data-port read word (combinational) |

## Verification
The bench builds the block with 4-word pages, 8 pages and an 8-word user region. With these values a full main erase takes 32 cycles, so the bench can count the ready-low window exactly for every erase kind. They also keep the main region small enough to fill with a distinct pattern and read back in full after each operation. A page-erase address above the 32-word main region is included, which exercises the page-index wrap.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RIDX_READY   = 3'd0;
  localparam logic [REG_AW-1:0] RIDX_MODE    = 3'd1;
  localparam logic [REG_AW-1:0] RIDX_PAGE_A  = 3'd2;
  localparam logic [REG_AW-1:0] RIDX_PAGE_B  = 3'd3;
  localparam logic [REG_AW-1:0] RIDX_ALL     = 3'd4;
  localparam logic [REG_AW-1:0] RIDX_USER    = 3'd5;

  typedef enum logic [1:0] {
    MODE_RO   = 2'd0,
    MODE_WEN  = 2'd1,
    MODE_EEN  = 2'd2,
    MODE_RSVD = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    ERS_PAGE = 2'd0,
    ERS_MAIN = 2'd1,
    ERS_USER = 2'd2
  } ers_kind_e;

endpackage

// File: rtl/fmc_word_ram.sv
module fmc_word_ram #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fmc_regs.sv
module fmc_regs
  import fmc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MAIN_AW = 11,
  parameter int PG_AW   = 3,
  localparam int PGI_W  = MAIN_AW - PG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        mode,
  output logic              cmd_valid,
  output ers_kind_e         cmd_kind,
  output logic [PGI_W-1:0]  cmd_page
);

  logic [1:0] mode_q, mode_d;
  logic       mode_en;
  logic       erase_ok;
  logic       unused_wdata;

  // Mode register: next state and register
  assign mode_en = reg_we && (reg_addr == RIDX_MODE);

  always_comb begin
    mode_d = mode_q;
    if (mode_en) begin
      mode_d = reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RO;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

  // Erase command decode, gated by mode and by a running erase
  assign erase_ok = reg_we && (mode_q == MODE_EEN) && !busy;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_kind  = ERS_PAGE;
    if (erase_ok) begin
      unique case (reg_addr)
        RIDX_PAGE_A, RIDX_PAGE_B: begin
          cmd_valid = 1'b1;
          cmd_kind  = ERS_PAGE;
        end
        RIDX_ALL: begin
          cmd_valid = reg_wdata[0];
          cmd_kind  = ERS_MAIN;
        end
        RIDX_USER: begin
          cmd_valid = reg_wdata[0];
          cmd_kind  = ERS_USER;
        end
        default: cmd_valid = 1'b0;
      endcase
    end
  end

  assign cmd_page = reg_wdata[MAIN_AW-1:PG_AW];

  // Read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RIDX_READY: reg_rdata = DATA_W'(!busy);
      RIDX_MODE:  reg_rdata = DATA_W'(mode_q);
      default:    reg_rdata = '0;
    endcase
  end

  assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/fmc_erase_seq.sv
module fmc_erase_seq
  import fmc_pkg::*;
#(
  parameter int MAIN_AW    = 11,
  parameter int PG_AW      = 3,
  parameter int USER_WORDS = 64,
  localparam int PGI_W     = MAIN_AW - PG_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  ers_kind_e          cmd_kind,
  input  logic [PGI_W-1:0]   cmd_page,
  output logic               busy,
  output logic [MAIN_AW-1:0] cur,
  output logic [MAIN_AW-1:0] last,
  output logic               to_user
);

  localparam logic [MAIN_AW-1:0] USER_LAST = MAIN_AW'(USER_WORDS - 1);

  logic               busy_q, busy_d;
  logic [MAIN_AW-1:0] cur_q, cur_d;
  logic [MAIN_AW-1:0] last_q, last_d;
  logic               user_q, user_d;

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    last_d = last_q;
    user_d = user_q;
    if (busy_q) begin
      if (cur_q == last_q) begin
        busy_d = 1'b0;
      end else begin
        cur_d = cur_q + 1'b1;
      end
    end else if (cmd_valid) begin
      busy_d = 1'b1;
      unique case (cmd_kind)
        ERS_PAGE: begin
          cur_d  = {cmd_page, {PG_AW{1'b0}}};
          last_d = {cmd_page, {PG_AW{1'b1}}};
          user_d = 1'b0;
        end
        ERS_MAIN: begin
          cur_d  = '0;
          last_d = '1;
          user_d = 1'b0;
        end
        default: begin
          cur_d  = '0;
          last_d = USER_LAST;
          user_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      user_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      last_q <= last_d;
      user_q <= user_d;
    end
  end

  assign busy    = busy_q;
  assign cur     = cur_q;
  assign last    = last_q;
  assign to_user = user_q;

endmodule

// File: rtl/fmc_ctrl.sv
module fmc_ctrl
  import fmc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 8,
  parameter int NUM_PAGES  = 256,
  parameter int USER_WORDS = 64,
  localparam int PG_AW     = $clog2(PAGE_WORDS),
  localparam int PGI_W     = $clog2(NUM_PAGES),
  localparam int MAIN_AW   = PG_AW + PGI_W,
  localparam int MAIN_WORDS = PAGE_WORDS * NUM_PAGES,
  localparam int USER_AW   = $clog2(USER_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               arr_we,
  input  logic               arr_user,
  input  logic [MAIN_AW-1:0] arr_addr,
  input  logic [DATA_W-1:0]  arr_wdata,
  output logic [DATA_W-1:0]  arr_rdata
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  logic [1:0]         mode;
  logic               cmd_valid;
  ers_kind_e          cmd_kind;
  logic [PGI_W-1:0]   cmd_page;
  logic               ers_busy;
  logic [MAIN_AW-1:0] ers_cur;
  logic [MAIN_AW-1:0] ers_last;
  logic               ers_user;

  fmc_regs #(
    .DATA_W (DATA_W),
    .MAIN_AW(MAIN_AW),
    .PG_AW  (PG_AW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .busy     (ers_busy),
    .reg_rdata(reg_rdata),
    .mode     (mode),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_page (cmd_page)
  );

  fmc_erase_seq #(
    .MAIN_AW   (MAIN_AW),
    .PG_AW     (PG_AW),
    .USER_WORDS(USER_WORDS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_page (cmd_page),
    .busy     (ers_busy),
    .cur      (ers_cur),
    .last     (ers_last),
    .to_user  (ers_user)
  );

  // Write steering: the erase sequencer owns the banks while it runs
  logic               host_ok;
  logic               main_we, user_we;
  logic [MAIN_AW-1:0] main_waddr;
  logic [USER_AW-1:0] user_waddr;
  logic [DATA_W-1:0]  main_wdata, user_wdata;
  logic [DATA_W-1:0]  main_rdata, user_rdata;
  logic               unused_addr;

  assign host_ok = arr_we && (mode == MODE_WEN) && !ers_busy;

  always_comb begin
    if (ers_busy) begin
      main_we    = !ers_user;
      user_we    = ers_user;
      main_waddr = ers_cur;
      user_waddr = ers_cur[USER_AW-1:0];
      main_wdata = '1;
      user_wdata = '1;
    end else begin
      main_we    = host_ok && !arr_user;
      user_we    = host_ok && arr_user;
      main_waddr = arr_addr;
      user_waddr = arr_addr[USER_AW-1:0];
      main_wdata = arr_wdata;
      user_wdata = arr_wdata;
    end
  end

  fmc_word_ram #(
    .WORDS (MAIN_WORDS),
    .DATA_W(DATA_W)
  ) u_main (
    .clk  (clk),
    .we   (main_we),
    .waddr(main_waddr),
    .wdata(main_wdata),
    .raddr(arr_addr),
    .rdata(main_rdata)
  );

  fmc_word_ram #(
    .WORDS (USER_WORDS),
    .DATA_W(DATA_W)
  ) u_user (
    .clk  (clk),
    .we   (user_we),
    .waddr(user_waddr),
    .wdata(user_wdata),
    .raddr(arr_addr[USER_AW-1:0]),
    .rdata(user_rdata)
  );

  assign arr_rdata   = arr_user ? user_rdata : main_rdata;
  assign unused_addr = ^ers_cur;

endmodule

// File: rtl/fmc_ctrl_chk.sv
module fmc_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int MAIN_AW = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic               ers_busy,
  input logic [MAIN_AW-1:0] ers_cur,
  input logic [MAIN_AW-1:0] ers_last,
  input logic               main_we,
  input logic               user_we,
  input logic [DATA_W-1:0]  main_wdata,
  input logic [DATA_W-1:0]  user_wdata
);

  AST_HOST_WRITE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_we || user_we) && !ers_busy) |-> (mode == 2'd1)); // R3

  AST_ERASE_START_NEEDS_EEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ers_busy) |-> ($past(mode) == 2'd2)); // R7

  AST_ONE_WORD_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_busy && (ers_cur != ers_last)) |=> (ers_busy && (ers_cur == $past(ers_cur) + 1'b1))); // R1

  AST_LAST_WORD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_busy && (ers_cur == ers_last)) |=> !ers_busy); // R1

  AST_ERASE_WRITES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ers_busy |-> ((main_we && main_wdata == {DATA_W{1'b1}}) ||
                  (user_we && user_wdata == {DATA_W{1'b1}}))); // R8

  AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_we, user_we})); // R8

endmodule

bind fmc_ctrl fmc_ctrl_chk #(
  .DATA_W (DATA_W),
  .MAIN_AW(MAIN_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mode      (mode),
  .ers_busy  (ers_busy),
  .ers_cur   (ers_cur),
  .ers_last  (ers_last),
  .main_we   (main_we),
  .user_we   (user_we),
  .main_wdata(main_wdata),
  .user_wdata(user_wdata)
);

// File: tb/fmc_ctrl_bench.sv
`timescale 1ns/1ps
module fmc_ctrl_bench;

  localparam int DW    = 32;
  localparam int PW    = 4;
  localparam int NP    = 8;
  localparam int UW    = 8;
  localparam int MW    = PW * NP;
  localparam int AW    = $clog2(MW);
  localparam logic [DW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [2:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          arr_we;
  logic          arr_user;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic [DW-1:0] arr_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fmc_ctrl #(
    .DATA_W    (DW),
    .PAGE_WORDS(PW),
    .NUM_PAGES (NP),
    .USER_WORDS(UW)
  ) u_fmc_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .arr_we   (arr_we),
    .arr_user (arr_user),
    .arr_addr (arr_addr),
    .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata)
  );

  function automatic logic [DW-1:0] pat(input bit user, input int i);
    return (user ? 32'hC3000000 : 32'hA5000000) + DW'(i);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic arr_wr(input bit u, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    arr_we = 1'b1; arr_user = u; arr_addr = AW'(a); arr_wdata = d;
    @(negedge clk);
    arr_we = 1'b0;
  endtask

  task automatic arr_rd(input bit u, input int a, output logic [DW-1:0] d);
    arr_user = u; arr_addr = AW'(a);
    #1;
    d = arr_rdata;
  endtask

  // Called right after an erase command; returns cycles with ready low
  task automatic wait_ready(output int cyc);
    logic [DW-1:0] v;
    cyc = 0;
    reg_rd(3'd0, v);
    while (v[0] == 1'b0 && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      reg_rd(3'd0, v);
    end
  endtask

  task automatic fill(input bit u, input int n);
    reg_wr(3'd1, 1);
    for (int i = 0; i < n; i++) arr_wr(u, i, pat(u, i));
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    reg_rd(3'd0, v); check("R1 ready after reset", v, 1);
    reg_rd(3'd1, v); check("R2 mode after reset", v, 0);
  endtask

  task automatic t_mode();
    logic [DW-1:0] v;
    for (int m = 0; m < 4; m++) begin
      reg_wr(3'd1, DW'(m));
      reg_rd(3'd1, v);
      check("R2 mode readback", v, DW'(m));
    end
    reg_wr(3'd1, 0);
  endtask

  task automatic t_main_erase();
    logic [DW-1:0] v;
    int cyc, bad;
    fill(1'b1, UW);
    reg_wr(3'd1, 2);
    reg_wr(3'd4, 1);
    wait_ready(cyc);
    check("R1 main erase ready-low cycles", DW'(cyc), DW'(MW));
    bad = 0;
    for (int i = 0; i < MW; i++) begin
      arr_rd(1'b0, i, v);
      if (v !== ONES) bad++;
    end
    check("R5 main words not all ones", DW'(bad), 0);
    bad = 0;
    for (int i = 0; i < UW; i++) begin
      arr_rd(1'b1, i, v);
      if (v !== pat(1'b1, i)) bad++;
    end
    check("R5 user words disturbed", DW'(bad), 0);
  endtask

  task automatic t_write_gate();
    logic [DW-1:0] v;
    reg_wr(3'd1, 0);
    arr_wr(1'b0, 5, 32'h12345678);
    arr_rd(1'b0, 5, v); check("R3 write in mode 0 ignored", v, ONES);
    reg_wr(3'd2 + 3'd0, 0);
    reg_wr(3'd1, 2);
    arr_wr(1'b0, 5, 32'h12345678);
    arr_rd(1'b0, 5, v); check("R3 write in mode 2 ignored", v, ONES);
    reg_wr(3'd1, 3);
    arr_wr(1'b0, 5, 32'h12345678);
    arr_rd(1'b0, 5, v); check("R3 write in mode 3 ignored", v, ONES);
    reg_wr(3'd1, 1);
    arr_wr(1'b0, 5, 32'h12345678);
    arr_rd(1'b0, 5, v); check("R3 write in mode 1 stored", v, 32'h12345678);
    arr_wr(1'b1, 2, 32'h0BADF00D);
    arr_rd(1'b1, 2, v); check("R3 user write in mode 1 stored", v, 32'h0BADF00D);
  endtask

  task automatic t_page();
    logic [DW-1:0] v;
    int cyc, bad;
    fill(1'b0, MW);
    reg_wr(3'd1, 2);
    reg_wr(3'd2, 9);
    wait_ready(cyc);
    check("R1 page erase ready-low cycles", DW'(cyc), DW'(PW));
    bad = 0;
    for (int i = 8; i < 12; i++) begin
      arr_rd(1'b0, i, v);
      if (v !== ONES) bad++;
    end
    check("R4 page 2 not erased", DW'(bad), 0);
    arr_rd(1'b0, 7, v);  check("R8 word below page kept", v, pat(1'b0, 7));
    arr_rd(1'b0, 12, v); check("R8 word above page kept", v, pat(1'b0, 12));
    reg_wr(3'd3, 37);
    wait_ready(cyc);
    bad = 0;
    for (int i = 4; i < 8; i++) begin
      arr_rd(1'b0, i, v);
      if (v !== ONES) bad++;
    end
    check("R4 second register with wrapped address", DW'(bad), 0);
    arr_rd(1'b0, 3, v); check("R8 word before wrapped page kept", v, pat(1'b0, 3));
  endtask

  task automatic t_user();
    logic [DW-1:0] v;
    int cyc, bad;
    fill(1'b0, 2);
    reg_wr(3'd1, 2);
    reg_wr(3'd5, 1);
    wait_ready(cyc);
    check("R1 user erase ready-low cycles", DW'(cyc), DW'(UW));
    bad = 0;
    for (int i = 0; i < UW; i++) begin
      arr_rd(1'b1, i, v);
      if (v !== ONES) bad++;
    end
    check("R6 user words not all ones", DW'(bad), 0);
    arr_rd(1'b0, 1, v); check("R6 main word kept", v, pat(1'b0, 1));
  endtask

  task automatic t_erase_gate();
    logic [DW-1:0] v;
    int cyc;
    fill(1'b0, MW);
    for (int m = 0; m < 4; m++) begin
      if (m != 2) begin
        reg_wr(3'd1, DW'(m));
        reg_wr(3'd4, 1);
        reg_rd(3'd0, v); check("R7 erase outside mode 2 ready", v, 1);
        arr_rd(1'b0, 20, v); check("R7 erase outside mode 2 data", v, pat(1'b0, 20));
      end
    end
    reg_wr(3'd1, 2);
    reg_wr(3'd4, 2);
    reg_rd(3'd0, v); check("R7 erase with bit0 clear ready", v, 1);
    arr_rd(1'b0, 20, v); check("R7 erase with bit0 clear data", v, pat(1'b0, 20));
    reg_wr(3'd2, 0);
    reg_wr(3'd4, 1);
    wait_ready(cyc);
    arr_rd(1'b0, 20, v); check("R7 erase while busy ignored", v, pat(1'b0, 20));
    arr_rd(1'b0, 0, v);  check("R4 page 0 erased", v, ONES);
    reg_wr(3'd1, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    arr_we = 1'b0; arr_user = 1'b0; arr_addr = '0; arr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mode();
    t_main_erase();
    t_write_gate();
    t_page();
    t_user();
    t_erase_gate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule